// File: doc/BRIEF.md
# ChaCha Double-Round Sequencer with Shared ARX Unit

This block runs ChaCha double rounds on a 16-word state of 32-bit words. It has one add-xor-rotate (ARX) unit, and the unit is shared across all steps. Each clock, a fixed schedule of 32 steps picks three word positions (a, b, d) and a left-rotate amount. The unit then updates two words of an internal register array in place. A pass through all 32 steps is one double round. A pass counter repeats the schedule as many times as the round-count input asks.

Software-side framing is outside this block: key and nonce layout, the final feed-forward sum and the keystream XOR. A host loads the 16 words in parallel while the engine is idle, pulses start with a count of passes, and waits for the one-cycle done pulse. It then reads the result from the parallel state output.

Top module: `chacha_idx_engine`

## Requirements
- R1: With busy low, a high load copies load_data into the state, which appears on state_out the next cycle; word i sits at bits [32i+31:32i] of both buses. A load while busy has no effect.
- R2: A step with positions (a, b, d) and rotate r sets word[a] to word[a]+word[b] mod 2^32. It then sets word[d] to the XOR of the old word[d] with that new word[a], rotated left by r; r is masked to its low 5 bits.
- R3: Step s takes its rotate from s mod 4 through the list 16, 12, 8, 7. Within quarter round (a, b, c, d), the four steps use the triples (a,b,d), (c,d,b), (a,b,d), (c,d,b) in that order.
- R4: The eight quarter rounds of a pass run in this order: four column groups (i, i+4, i+8, i+12) for i = 0..3, then four diagonal groups (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14).
- R5: A start while idle with a nonzero count N raises busy on the next cycle. It completes exactly one step per clock, raises done exactly 32·N clock edges after the edge that sampled start, and drops busy in the same cycle that done rises.
- R6: done is high for exactly one cycle per accepted start.
- R7: A start while busy is ignored: neither the result nor the done timing changes.
- R8: A start with a count of zero raises done on the next cycle, keeps busy low, and leaves the state unchanged.
- R9: While idle and not loading, state_out holds its value, so the result stays stable after done until the next load.
- R10: For any loaded state, including one that begins 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574, the result after N passes equals N standard ChaCha double rounds (N = 1, 2, 3, 10 checked).
- R11: After reset, busy and done are low and every state word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load the state from load_data (idle only) |
| load_data | input | 512 | Sixteen 32-bit words to load |
| start | input | 1 | Begin a run (idle only) |
| rounds | input | RW (8) | Number of double-round passes |
| busy | output | 1 | Engine is stepping |
| done | output | 1 | One-cycle pulse after the last step |
| state_out | output | 512 | Sixteen 32-bit state words |

## Verification
A wrong table entry, rotate or operand order spreads through the ARX diffusion. After one pass it touches almost every output word, so a single-pass run shows it right after done, in the full 512-bit compare with the model. A counter off by one shows up as done arriving 32 cycles early or late, or a step missing, and the bench counts the exact cycle of done against 32·N. A load or start that leaks in while busy changes either the final words or that count. State corruption while idle appears as a change on state_out during the hold window after done.

// File: rtl/chx_pkg.sv
package chx_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_WORDS = 16;
  localparam int IDX_W    = $clog2(NUM_WORDS);
  localparam int ROT_W    = $clog2(WORD_W);
  localparam int STEPS    = 32;
  localparam int STEP_W   = $clog2(STEPS);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [IDX_W-1:0] a;
    logic [IDX_W-1:0] b;
    logic [IDX_W-1:0] d;
    logic [ROT_W-1:0] rot;
  } op_t;
endpackage

// File: rtl/chx_sched.sv
module chx_sched
  import chx_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output op_t               op
);
  logic [2:0] qr;
  logic [1:0] sub;
  logic [IDX_W-1:0] grp [4];

  assign qr  = step[4:2];
  assign sub = step[1:0];

  // member i of a group lives in row i; column shifts by i on diagonal passes
  for (genvar i = 0; i < 4; i++) begin : g_member
    logic [1:0] lane;
    assign lane   = qr[2] ? (qr[1:0] + 2'(i)) : qr[1:0];
    assign grp[i] = {2'(i), lane};
  end

  always_comb begin
    op.a = sub[0] ? grp[2] : grp[0];
    op.b = sub[0] ? grp[3] : grp[1];
    op.d = sub[0] ? grp[1] : grp[3];
    unique case (sub)
      2'd0:    op.rot = ROT_W'(16);
      2'd1:    op.rot = ROT_W'(12);
      2'd2:    op.rot = ROT_W'(8);
      default: op.rot = ROT_W'(7);
    endcase
  end
endmodule

// File: rtl/chx_arx.sv
module chx_arx
  import chx_pkg::*;
(
  input  word_t            wa,
  input  word_t            wb,
  input  word_t            wd,
  input  logic [ROT_W-1:0] rot,
  output word_t            sum,
  output word_t            mixed
);
  word_t                  mix;
  logic [2*WORD_W-1:0]    dbl;
  logic [2*WORD_W-1:0]    shr;
  logic [ROT_W-1:0]       r;

  assign r   = rot & {ROT_W{1'b1}};
  assign sum = wa + wb;
  assign mix = wd ^ sum;
  assign dbl = {mix, mix};
  assign shr = dbl >> (WORD_W - int'(r));
  assign mixed = shr[WORD_W-1:0];
endmodule

// File: rtl/chx_ctrl.sv
module chx_ctrl
  import chx_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RW-1:0]     rounds,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] step
);
  logic [RW-1:0] pass_q;
  logic          last_step;

  assign last_step = (step == STEP_W'(STEPS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step   <= '0;
      pass_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          step   <= '0;
          pass_q <= rounds;
          if (rounds == '0) done <= 1'b1;
          else              busy <= 1'b1;
        end
      end else begin
        step <= step + 1'b1;
        if (last_step) begin
          pass_q <= pass_q - 1'b1;
          if (pass_q == RW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) || $past(start)));
  // R7
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> step == $past(step) + 1'b1);
  // R5
  pass_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && last_step) |=> pass_q == $past(pass_q) - 1'b1);
endmodule

// File: rtl/chacha_idx_engine.sv
module chacha_idx_engine
  import chx_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [NUM_WORDS*WORD_W-1:0]   load_data,
  input  logic                          start,
  input  logic [RW-1:0]                 rounds,
  output logic                          busy,
  output logic                          done,
  output logic [NUM_WORDS*WORD_W-1:0]   state_out
);
  word_t             st [NUM_WORDS];
  logic [STEP_W-1:0] step;
  op_t               op;
  word_t             sum, mixed;

  chx_ctrl #(.RW(RW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .rounds(rounds),
    .busy(busy), .done(done), .step(step)
  );

  chx_sched u_sched (.step(step), .op(op));

  chx_arx u_arx (
    .wa(st[op.a]), .wb(st[op.b]), .wd(st[op.d]), .rot(op.rot),
    .sum(sum), .mixed(mixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) st[i] <= '0;
    end else if (busy) begin
      st[op.a] <= sum;
      st[op.d] <= mixed;
    end else if (load) begin
      for (int i = 0; i < NUM_WORDS; i++)
        st[i] <= load_data[i*WORD_W +: WORD_W];
    end
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_out
    assign state_out[i*WORD_W +: WORD_W] = st[i];
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> $stable(state_out));
  // R1
  busy_noload_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && load && op.a != 4'd0 && op.d != 4'd0)
      |=> state_out[WORD_W-1:0] == $past(state_out[WORD_W-1:0]));
endmodule

// File: tb/sim_chacha_idx_engine.sv
`timescale 1ns/1ps
module sim_chacha_idx_engine;
  typedef logic [15:0][31:0] blk_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  blk_t       load_data = '0;
  logic       start = 1'b0;
  logic [7:0] rounds = '0;
  logic       busy, done;
  blk_t       state_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chacha_idx_engine #(.RW(8)) u0 (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .start(start), .rounds(rounds), .busy(busy), .done(done),
    .state_out(state_out)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int r);
    return (x << r) | (x >> (32 - r));
  endfunction

  function automatic blk_t model(input blk_t s, input int n);
    blk_t w = s;
    for (int p = 0; p < n; p++) begin
      for (int q = 0; q < 8; q++) begin
        int a, b, c, d;
        int col = q % 4;
        if (q < 4) begin
          a = col; b = col + 4; c = col + 8; d = col + 12;
        end else begin
          a = col; b = 4 + (col + 1) % 4; c = 8 + (col + 2) % 4; d = 12 + (col + 3) % 4;
        end
        w[a] = w[a] + w[b]; w[d] = rl(w[d] ^ w[a], 16);
        w[c] = w[c] + w[d]; w[b] = rl(w[b] ^ w[c], 12);
        w[a] = w[a] + w[b]; w[d] = rl(w[d] ^ w[a], 8);
        w[c] = w[c] + w[d]; w[b] = rl(w[b] ^ w[c], 7);
      end
    end
    return w;
  endfunction

  function automatic blk_t pattern(input int seed);
    blk_t v;
    logic [31:0] x = 32'h9e3779b9 ^ 32'(seed);
    for (int i = 0; i < 16; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      v[i] = x;
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input blk_t act, input blk_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input blk_t v);
    @(negedge clk); load = 1'b1; load_data = v;
    @(negedge clk); load = 1'b0;
  endtask

  // start sampled at edge P0; done seen at the negedge after P(32N)
  task automatic run(input int n, input bit disturb, input blk_t init, output blk_t res);
    int lat = (n == 0) ? 1 : 32 * n + 1;
    int k = 0;
    @(negedge clk); start = 1'b1; rounds = 8'(n);
    do begin
      @(negedge clk); k++;
      start = 1'b0;
      if (k == 1) chk(busy == (n != 0), "R5/R8 busy after start", blk_t'(busy), blk_t'(n != 0));
      if (disturb && k == 10) begin
        start = 1'b1; rounds = 8'd3; load = 1'b1; load_data = ~init;
      end
      if (disturb && k == 11) load = 1'b0;
    end while (!done && k < lat + 40);
    start = 1'b0; load = 1'b0;
    chk(k == lat, disturb ? "R7 done timing" : "R5 done timing", blk_t'(k), blk_t'(lat));
    chk(!busy, "R5 busy low with done", blk_t'(busy), '0);
    res = state_out;
    @(negedge clk);
    chk(!done, "R6 single done", blk_t'(done), '0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    blk_t refv, res, hold;
    refv = pattern(7);
    refv[0] = 32'h61707865; refv[1] = 32'h3320646e;
    refv[2] = 32'h79622d32; refv[3] = 32'h6b206574;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && state_out == '0, "R11 reset state", state_out, '0);

    do_load(refv);
    chk(state_out == refv, "R1 load readback", state_out, refv);

    run(2, 1'b0, refv, res);
    chk(res == model(refv, 2), "R10 two passes", res, model(refv, 2));
    hold = state_out;
    repeat (6) @(negedge clk);
    chk(state_out == hold, "R9 hold after done", state_out, hold);

    do_load(refv);
    run(10, 1'b0, refv, res);
    chk(res == model(refv, 10), "R10 ten passes", res, model(refv, 10));

    do_load(refv);
    run(1, 1'b1, refv, res);
    chk(res == model(refv, 1), "R7 R1 start/load while busy ignored", res, model(refv, 1));

    hold = state_out;
    run(0, 1'b0, hold, res);
    chk(res == hold, "R8 zero count keeps state", res, hold);

    // single nonzero words probe the R2/R3/R4 step order and rotates
    for (int i = 0; i < 16; i++) begin
      blk_t v = '0;
      v[i] = 32'h1 << i;
      do_load(v);
      run(1, 1'b0, v, res);
      chk(res == model(v, 1), $sformatf("R2 R3 R4 unit word %0d", i), res, model(v, 1));
    end

    for (int p = 0; p < 6; p++) begin
      for (int n = 1; n <= 3; n++) begin
        blk_t v = pattern(p * 10 + n);
        do_load(v);
        run(n, 1'b0, v, res);
        chk(res == model(v, n), "R10 sweep", res, model(v, n));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule